// File: doc/BRIEF.md
# Hardware Cursor Scanline Overlay

This block lays a 64x64 two-plane hardware cursor over the pixel stream of a single display line. At the start of each line it checks whether the line falls inside the cursor's vertical span. If it does, it reads that cursor row from memory: sixteen bytes, one per cycle, over a byte-wide read port with one cycle of latency. The bytes land in a small row buffer. As pixels stream through, each pixel whose column lies under the cursor and inside the active display width is replaced by a cursor colour, passed through unchanged, or has its RGB inverted. The choice depends on the pair of mask and colour-select bits for that pixel.

The cursor base offset carries a freeze flag in its top bit. While the flag is set, no row is fetched and the overlay keeps using the row that is already held. The display width comes from a horizontal display field, and the cursor is cut off at that width rather than carried over to the next line. Memory arbitration, frame timing and the register interface belong to the surrounding logic. The pixel stream must start after the row read is complete, which is at least 18 cycles after the line strobe.

Top module: `hcur_overlay`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_rd_en` and `pix_out_valid` are 0 and `pix_out` is zero.
- R2: A `line_start` pulse with `line_num` in the range `cur_y` to `cur_y`+63 and `cur_base[31]` clear produces exactly 16 read strobes on consecutive cycles, starting the cycle after the pulse. The addresses run from `{1'b0,cur_base[30:0]}` + (`line_num`-`cur_y`)*16 upwards by one.
- R3: A line outside the cursor's vertical span produces no read strobe, and every pixel of it leaves the block unchanged.
- R4: With `cur_base[31]` set, a line pulse issues no read. The overlay keeps the row bytes captured by the last completed fetch.
- R5: A cursor pixel whose mask bit is 0 is opaque. Its output is `{8'hFF, color1}` when its select bit is 1 and `{8'hFF, color0}` when it is 0.
- R6: A cursor pixel with mask bit 1 and select bit 0 passes the input pixel unchanged.
- R7: A cursor pixel with mask bit 1 and select bit 1 outputs the input alpha byte `[31:24]` with the RGB bits `[23:0]` inverted.
- R8: Cursor pixel k (k = `pix_col`-`cur_x`, 0..63) takes its mask bit from row byte k/8 and its select bit from row byte 8+k/8, in both cases bit 7-(k mod 8), so the most significant bit comes first.
- R9: Columns left of `cur_x`, at or beyond `cur_x`+64, or at or beyond the display width (`hdisp_field`+1)*8 pass unchanged.
- R10: `pix_out_valid` and `pix_out` follow `pix_in_valid` and `pix_in` by exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | One-cycle pulse at the start of a display line |
| line_num | input | 12 | Index of the line that is starting |
| cur_base | input | 32 | Cursor image byte offset in bits [30:0]; bit 31 freezes the row |
| cur_x | input | 12 | Cursor left column |
| cur_y | input | 12 | Cursor top line |
| color0 | input | 24 | Opaque colour used when the select bit is 0 |
| color1 | input | 24 | Opaque colour used when the select bit is 1 |
| hdisp_field | input | 11 | Horizontal display field; width = (field+1)*8 |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_addr | output | 32 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_col | input | 12 | Column of the input pixel |
| pix_in | input | 32 | Input pixel, alpha in [31:24], RGB in [23:0] |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 32 | Output pixel |

## Verification
On every cycle the assertions check the fetch rules: a frozen line or a missed line issues no strobe, addresses within a burst step by one, and no burst runs past sixteen reads. They also check one-cycle pixel latency, pass-through beyond the display width and on missed lines, the forced opaque alpha, and inversion that keeps alpha. The exact per-pixel mapping needs the bench's directed scenarios. Those scenarios cover the bit order inside a byte, the pairing of mask and select bytes, the choice between the two colours, and the row address at the last cursor line. They also show that a frozen line reuses the previously captured row, which only a known memory image can reveal.

// File: rtl/hcur_pkg.sv
package hcur_pkg;

   typedef enum logic [1:0] {
      PK_PASS   = 2'd0,
      PK_COLOR0 = 2'd1,
      PK_COLOR1 = 2'd2,
      PK_INVERT = 2'd3
   } pix_kind_e;

   // mask bit 0 -> opaque colour chosen by select bit; mask 1 -> pass or invert
   function automatic pix_kind_e hcur_classify(input logic mask_b, input logic sel_b);
      if (!mask_b) return sel_b ? PK_COLOR1 : PK_COLOR0;
      return sel_b ? PK_INVERT : PK_PASS;
   endfunction

endpackage

// File: rtl/hcur_fetch.sv
module hcur_fetch #(
   parameter int ADDR_W  = 32,
   parameter int POS_W   = 12,
   parameter int CUR_DIM = 64,
   localparam int ROW_BYTES = CUR_DIM / 4,
   localparam int IDX_W     = $clog2(ROW_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic [POS_W-1:0]  line_num,
   input  logic [POS_W-1:0]  cur_y,
   input  logic [ADDR_W-1:0] cur_base,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              line_hit
);
   localparam int ROW_W = $clog2(CUR_DIM);

   logic [POS_W:0]    diff;
   logic              in_rng;
   logic              frozen;
   logic [ADDR_W-1:0] row_start;
   logic [ADDR_W-1:0] row_addr;
   logic [IDX_W-1:0]  cnt;
   logic              busy;
   logic              rd_q;
   logic [IDX_W-1:0]  idx_q;

   assign diff      = {1'b0, line_num} - {1'b0, cur_y};
   assign in_rng    = !diff[POS_W] && (diff < (POS_W+1)'(CUR_DIM));
   assign frozen    = cur_base[ADDR_W-1];
   assign row_start = {1'b0, cur_base[ADDR_W-2:0]} + (ADDR_W'(diff[ROW_W-1:0]) << IDX_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         row_addr <= '0;
         line_hit <= 1'b0;
         rd_q     <= 1'b0;
         idx_q    <= '0;
      end else begin
         rd_q  <= busy;
         idx_q <= cnt;
         if (line_start) begin
            line_hit <= in_rng;
            busy     <= in_rng && !frozen;
            cnt      <= '0;
            row_addr <= row_start;
         end else if (busy) begin
            cnt <= cnt + IDX_W'(1);
            if (cnt == IDX_W'(ROW_BYTES - 1)) busy <= 1'b0;
         end
      end
   end

   assign mem_rd_en = busy;
   assign mem_addr  = row_addr + ADDR_W'(cnt);
   assign wr_en     = rd_q;
   assign wr_idx    = idx_q;

   // burst length monitor
   logic [IDX_W:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       run_len <= '0;
      else if (mem_rd_en && !line_start) run_len <= run_len + (IDX_W+1)'(1);
      else                              run_len <= '0;
   end

   // R4
   frozen_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start && frozen |=> !mem_rd_en);
   // R3
   miss_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start && !in_rng |=> !mem_rd_en);
   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en && $past(mem_rd_en) && !$past(line_start) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));
   // R2
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= (IDX_W+1)'(ROW_BYTES));

endmodule

// File: rtl/hcur_rowbuf.sv
module hcur_rowbuf #(
   parameter int CUR_DIM = 64,
   localparam int PLANE_B   = CUR_DIM / 8,
   localparam int ROW_BYTES = 2 * PLANE_B,
   localparam int IDX_W     = $clog2(ROW_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [7:0]         wr_data,
   output logic [CUR_DIM-1:0] mask_bits,
   output logic [CUR_DIM-1:0] sel_bits
);
   logic [ROW_BYTES*8-1:0] row_q;

   // reset image: mask plane all ones, select plane zero -> fully transparent
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= {{(PLANE_B*8){1'b0}}, {(PLANE_B*8){1'b1}}};
      end else if (wr_en) begin
         for (int b = 0; b < ROW_BYTES; b++) begin
            if (wr_idx == IDX_W'(b)) row_q[b*8 +: 8] <= wr_data;
         end
      end
   end

   // pixel p: byte p/8, most significant bit first
   for (genvar p = 0; p < CUR_DIM; p++) begin : g_map
      assign mask_bits[p] = row_q[(p/8)*8 + 7 - (p%8)];
      assign sel_bits[p]  = row_q[(PLANE_B + p/8)*8 + 7 - (p%8)];
   end

endmodule

// File: rtl/hcur_blend.sv
module hcur_blend
   import hcur_pkg::*;
#(
   parameter int POS_W    = 12,
   parameter int HFIELD_W = 11,
   parameter int CUR_DIM  = 64,
   parameter int COL_W    = 24,
   parameter bit OUT_REG  = 1'b1,
   localparam int PIX_W   = COL_W + 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_hit,
   input  logic                pix_in_valid,
   input  logic [POS_W-1:0]    pix_col,
   input  logic [PIX_W-1:0]    pix_in,
   input  logic [POS_W-1:0]    cur_x,
   input  logic [HFIELD_W-1:0] hdisp_field,
   input  logic [COL_W-1:0]    color0,
   input  logic [COL_W-1:0]    color1,
   input  logic [CUR_DIM-1:0]  mask_bits,
   input  logic [CUR_DIM-1:0]  sel_bits,
   output logic                pix_out_valid,
   output logic [PIX_W-1:0]    pix_out
);
   localparam int WID_W = HFIELD_W + 4;
   localparam int CMP_W = ((WID_W > POS_W) ? WID_W : POS_W) + 1;
   localparam int ROW_W = $clog2(CUR_DIM);

   logic [CMP_W-1:0] disp_w, col_e, x_e, off;
   logic             in_win;
   logic [ROW_W-1:0] idx;
   pix_kind_e        kind;
   logic [PIX_W-1:0] mixed;

   assign disp_w = (CMP_W'(hdisp_field) + CMP_W'(1)) << 3;
   assign col_e  = CMP_W'(pix_col);
   assign x_e    = CMP_W'(cur_x);
   assign off    = col_e - x_e;
   assign in_win = line_hit && (col_e >= x_e) && (off < CMP_W'(CUR_DIM)) && (col_e < disp_w);
   assign idx    = off[ROW_W-1:0];
   assign kind   = in_win ? hcur_classify(mask_bits[idx], sel_bits[idx]) : PK_PASS;

   always_comb begin
      case (kind)
         PK_COLOR0: mixed = {8'hFF, color0};
         PK_COLOR1: mixed = {8'hFF, color1};
         PK_INVERT: mixed = {pix_in[PIX_W-1:COL_W], ~pix_in[COL_W-1:0]};
         default:   mixed = pix_in;
      endcase
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pix_out_valid <= 1'b0;
            pix_out       <= '0;
         end else begin
            pix_out_valid <= pix_in_valid;
            pix_out       <= mixed;
         end
      end

      // R10
      lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pix_in_valid |=> pix_out_valid);
      // R10
      idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !pix_in_valid |=> !pix_out_valid);
      // R9
      clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pix_in_valid && (col_e >= disp_w) |=> pix_out == $past(pix_in));
      // R3
      miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pix_in_valid && !line_hit |=> pix_out == $past(pix_in));
      // R5
      opaque_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pix_in_valid && in_win && !mask_bits[idx] |=> pix_out[PIX_W-1:COL_W] == 8'hFF);
      // R7
      invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pix_in_valid && in_win && mask_bits[idx] && sel_bits[idx]
         |=> pix_out == {$past(pix_in[PIX_W-1:COL_W]), ~$past(pix_in[COL_W-1:0])});
   end else begin : g_comb
      assign pix_out_valid = pix_in_valid;
      assign pix_out       = mixed;
   end

endmodule

// File: rtl/hcur_overlay.sv
module hcur_overlay #(
   parameter int ADDR_W   = 32,
   parameter int POS_W    = 12,
   parameter int HFIELD_W = 11,
   parameter int COL_W    = 24,
   parameter int CUR_DIM  = 64,
   parameter bit OUT_REG  = 1'b1,
   localparam int PIX_W   = COL_W + 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_start,
   input  logic [POS_W-1:0]    line_num,
   input  logic [ADDR_W-1:0]   cur_base,
   input  logic [POS_W-1:0]    cur_x,
   input  logic [POS_W-1:0]    cur_y,
   input  logic [COL_W-1:0]    color0,
   input  logic [COL_W-1:0]    color1,
   input  logic [HFIELD_W-1:0] hdisp_field,
   output logic                mem_rd_en,
   output logic [ADDR_W-1:0]   mem_addr,
   input  logic [7:0]          mem_rdata,
   input  logic                pix_in_valid,
   input  logic [POS_W-1:0]    pix_col,
   input  logic [PIX_W-1:0]    pix_in,
   output logic                pix_out_valid,
   output logic [PIX_W-1:0]    pix_out
);
   localparam int ROW_BYTES = CUR_DIM / 4;
   localparam int IDX_W     = $clog2(ROW_BYTES);

   if ((CUR_DIM < 8) || (CUR_DIM % 8 != 0) || ((CUR_DIM & (CUR_DIM - 1)) != 0)) begin : g_bad_dim
      $error("hcur_overlay: CUR_DIM must be a power of two of at least 8");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("hcur_overlay: ADDR_W too small");
   end
   if ((1 << POS_W) < CUR_DIM) begin : g_bad_pos
      $error("hcur_overlay: POS_W cannot span the cursor");
   end

   logic               wr_en;
   logic [IDX_W-1:0]   wr_idx;
   logic               line_hit;
   logic [CUR_DIM-1:0] mask_bits;
   logic [CUR_DIM-1:0] sel_bits;

   hcur_fetch #(
      .ADDR_W(ADDR_W), .POS_W(POS_W), .CUR_DIM(CUR_DIM)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
      .cur_y(cur_y), .cur_base(cur_base), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .wr_en(wr_en), .wr_idx(wr_idx), .line_hit(line_hit)
   );

   hcur_rowbuf #(
      .CUR_DIM(CUR_DIM)
   ) u_rowbuf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(mem_rdata),
      .mask_bits(mask_bits), .sel_bits(sel_bits)
   );

   hcur_blend #(
      .POS_W(POS_W), .HFIELD_W(HFIELD_W), .CUR_DIM(CUR_DIM), .COL_W(COL_W), .OUT_REG(OUT_REG)
   ) u_blend (
      .clk(clk), .rst_n(rst_n), .line_hit(line_hit), .pix_in_valid(pix_in_valid),
      .pix_col(pix_col), .pix_in(pix_in), .cur_x(cur_x), .hdisp_field(hdisp_field),
      .color0(color0), .color1(color1), .mask_bits(mask_bits), .sel_bits(sel_bits),
      .pix_out_valid(pix_out_valid), .pix_out(pix_out)
   );

endmodule

// File: tb/sim_hcur_overlay.sv
module sim_hcur_overlay;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        line_start;
   logic [11:0] line_num;
   logic [31:0] cur_base;
   logic [11:0] cur_x, cur_y;
   logic [23:0] color0, color1;
   logic [10:0] hdisp_field;
   logic        mem_rd_en;
   logic [31:0] mem_addr;
   logic [7:0]  mem_rdata;
   logic        pix_in_valid;
   logic [11:0] pix_col;
   logic [31:0] pix_in;
   logic        pix_out_valid;
   logic [31:0] pix_out;

   logic [7:0]  bmem [2048];
   logic [7:0]  exp_row [16];
   logic        exp_hit;
   int          checks = 0;
   int          errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (mem_rd_en) mem_rdata <= bmem[mem_addr[10:0]];

   hcur_overlay u0 (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
      .cur_base(cur_base), .cur_x(cur_x), .cur_y(cur_y), .color0(color0), .color1(color1),
      .hdisp_field(hdisp_field), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .pix_in_valid(pix_in_valid), .pix_col(pix_col),
      .pix_in(pix_in), .pix_out_valid(pix_out_valid), .pix_out(pix_out)
   );

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mkpix(input int col);
      return {8'h6C, 8'(col), ~8'(col), 8'(col * 5 + 3)};
   endfunction

   // expected output for one pixel, derived from the requirements
   task automatic model(input int col, input logic [31:0] p, output logic [31:0] e, output string tag);
      int width, k;
      logic mb, sb;
      width = (int'(hdisp_field) + 1) * 8;
      if (!exp_hit) begin
         e = p; tag = "R3 miss line pass";
      end else if (col < int'(cur_x) || col >= int'(cur_x) + 64 || col >= width) begin
         e = p; tag = "R9 outside window pass";
      end else begin
         k  = col - int'(cur_x);
         mb = exp_row[k/8][7 - k%8];
         sb = exp_row[8 + k/8][7 - k%8];
         if (!mb)      begin e = {8'hFF, sb ? color1 : color0}; tag = "R5 opaque"; end
         else if (!sb) begin e = p; tag = "R6 transparent"; end
         else          begin e = {p[31:24], ~p[23:0]}; tag = "R7 invert"; end
      end
   endtask

   task automatic do_line(input int ln);
      int  row;
      bit  hit, fetch, en;
      logic [31:0] base;
      row   = ln - int'(cur_y);
      hit   = (row >= 0) && (row < 64);
      fetch = hit && !cur_base[31];
      base  = {1'b0, cur_base[30:0]};
      @(negedge clk);
      line_start = 1'b1;
      line_num   = 12'(ln);
      @(negedge clk);
      line_start = 1'b0;
      for (int i = 1; i <= 20; i++) begin
         en = fetch && (i <= 16);
         check32(fetch ? "R2 read strobe" : (hit ? "R4 frozen read strobe" : "R3 miss read strobe"),
                 32'(mem_rd_en), 32'(en));
         if (en) check32("R2 read address", mem_addr, base + 32'(row * 16 + i - 1));
         @(negedge clk);
      end
      exp_hit = hit;
      if (fetch) for (int k = 0; k < 16; k++) exp_row[k] = bmem[11'(base + 32'(row * 16 + k))];
   endtask

   task automatic stream(input int c_lo, input int c_hi, input string note);
      logic [31:0] e;
      string tag;
      for (int c = c_lo; c <= c_hi; c++) begin
         pix_in_valid = 1'b1;
         pix_col      = 12'(c);
         pix_in       = mkpix(c);
         @(negedge clk);
         check32({"R10 valid follows input", note}, 32'(pix_out_valid), 32'd1);
         model(c, mkpix(c), e, tag);
         check32({tag, note}, pix_out, e);
      end
      pix_in_valid = 1'b0;
      @(negedge clk);
      check32({"R10 valid drops", note}, 32'(pix_out_valid), 32'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check32("R1 read strobe in reset", 32'(mem_rd_en), 32'd0);
      check32("R1 valid in reset", 32'(pix_out_valid), 32'd0);
      check32("R1 pixel in reset", pix_out, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check32("R1 valid after reset", 32'(pix_out_valid), 32'd0);
      check32("R1 read strobe after reset", 32'(mem_rd_en), 32'd0);
   endtask

   task automatic t_modes();
      cur_base = 32'h0000_0100; cur_y = 12'd10; cur_x = 12'd16; hdisp_field = 11'd79;
      // row 3: byte 0 mask 0x0F, byte 8 select 0x33 -> c0 c0 c1 c1 pass pass inv inv
      bmem[11'h100 + 48]     = 8'h0F;
      bmem[11'h100 + 48 + 8] = 8'h33;
      do_line(13);
      stream(0, 100, " R8 bit order");
   endtask

   task automatic t_last_row();
      do_line(73);
      stream(10, 90, " R2 last row");
   endtask

   task automatic t_outside();
      do_line(9);
      stream(10, 40, " above span");
      do_line(74);
      stream(10, 40, " below span");
   endtask

   task automatic t_clip();
      hdisp_field = 11'd9;  // width 80
      cur_x = 12'd60;
      do_line(20);
      stream(50, 110, " R9 display clip");
      hdisp_field = 11'd79;
      cur_x = 12'd16;
   endtask

   task automatic t_freeze();
      cur_base = 32'h0000_0100;
      do_line(30);
      stream(16, 40, " before freeze");
      cur_base = 32'h8000_0100;
      do_line(31);
      stream(16, 82, " R4 held row");
      cur_base = 32'h0000_0100;
      do_line(31);
      stream(16, 82, " R4 after unfreeze");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      line_start = 1'b0; line_num = '0; cur_base = '0; cur_x = '0; cur_y = '0;
      color0 = 24'h123456; color1 = 24'hABCDEF; hdisp_field = 11'd79;
      pix_in_valid = 1'b0; pix_col = '0; pix_in = '0; exp_hit = 1'b0;
      for (int a = 0; a < 2048; a++) bmem[a] = 8'((a * 37 + 11) ^ (a >> 3));
      for (int k = 0; k < 16; k++) exp_row[k] = (k < 8) ? 8'hFF : 8'h00;
      t_reset();
      t_modes();
      t_last_row();
      t_outside();
      t_clip();
      t_freeze();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule